// File: doc/BRIEF.md
# Byte-wide RAM with BCD calendar clock overlay

This block is a byte-wide static RAM whose eight highest addresses are not storage but calendar and clock registers. The host reaches them through the same chip-enable, output-enable and write-enable byte bus that it uses for the rest of the array, so software reads and sets the time with ordinary memory cycles. The address width is a parameter: 15 address bits give 32K x 8, and the default of 11 gives 2K x 8. The clock window always starts at BASE = 2^ADDR_W - 8.

Internally, a set of live counters keeps packed-BCD seconds, minutes, hours, day of week, date, month, year and century. They advance on a synchronous once-per-second tick enable and handle month lengths and leap years. The host never sees the counters directly. It sees a bank of holding registers that normally follow the counters. A read-freeze bit gives the host a stable snapshot. A write-freeze bit lets the host compose a new time, which is transferred into the counters when the bit is cleared. A stop bit halts timekeeping. A frequency-test bit echoes the tick on a status pin. A battery-low input shows up as a read-only flag. Bits of the clock bytes that carry no function behave as plain RAM bits.

Top module: `rtc_nvram`

## Requirements
- R1: Writes and reads at addresses below BASE behave as RAM. The stored byte appears on rdata while ce_n=0, oe_n=0 and we_n=1, and rdata_en is 1 in exactly that state.
- R2: A write is captured at the rising clock edge whenever ce_n=0 and we_n=0, whatever oe_n is. rdata_en is 0 whenever we_n=0 or ce_n=1.
- R3: The clock bytes sit at fixed offsets from BASE, as packed BCD in the masked bits:
  - +0 century, bits 5:0
  - +1 seconds, bits 6:0
  - +2 minutes, bits 6:0
  - +3 hours, bits 5:0
  - +4 day of week, bits 2:0
  - +5 date, bits 5:0
  - +6 month, bits 4:0
  - +7 year, bits 7:0
- R4: These bits hold whatever the host last wrote, like RAM:
  - minutes bit 7
  - hours bits 7:6
  - day bits 5:3
  - date bits 7:6
  - month bits 7:5
- R5: Each tick advances seconds. Seconds 59 and minutes 59 wrap to 00 with a carry. Hours 23 wraps to 00 and advances both day of week (07 wraps to 01) and date. A change is readable two clock cycles after the edge that samples the tick.
- R6: The date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, and after 31 in all other months except February. February ends after 29 when the BCD year is divisible by 4 (including 00), and after 28 otherwise.
- R7: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century. Century 39 wraps to 00.
- R8: Century bit 7 is the write bit. While it is 1, the holding registers stop following the counters and keep host-written values while the counters run on. Writing the century byte with bit 7 = 0 while the bit is 1 loads all holding time fields into the counters; ticks counted during the freeze are discarded. With the bit at 0, host-written time bits are replaced by live values.
- R9: Century bit 6 is the read bit. While it is 1, the holding time fields are frozen and the counters keep running. Clearing it makes the holding registers show the live time again.
- R10: Seconds bit 7 is the stop bit. While it is 1, ticks have no effect on any counter.
- R11: Day bit 7 reads as the inverse of batt_low, and writes to it have no effect.
- R12: Day bit 6 is the frequency-test bit. While it is 1, ftest_out is 1 for the one cycle after each clock edge that samples sec_tick=1. While it is 0, ftest_out stays 0.
- R13: After reset the clock reads century 20, year 00, month 01, date 01, day 01, time 00:00:00, with all control and spare bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | Synchronous tick enable, TICKS_PER_SEC per second |
| batt_low | input | 1 | Battery-low status |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid when rdata_en is 1 |
| rdata_en | output | 1 | Output-drive enable for the data bus |
| ftest_out | output | 1 | Frequency-test echo of the tick |

## Verification
The bench sets the time just before midnight and steps across the calendar edges that designs most often get wrong. In a non-leap February, a design that tests the leap rule badly lands on the 29th. In a leap February, a design with a missing leap check skips the 29th. Year 00 must be treated as a leap year. A 30-day month that wraps late would show the 31st. At December 31 of year 99 the century must step, and century 39 must wrap to 00; a broken carry would leave the century unchanged or show a non-BCD digit. Further cases cover:
- ticks taken during a write freeze, which must be discarded when the freeze is released;
- a read freeze that fails to hold its snapshot;
- a stop bit that leaks ticks;
- spare bits that get overwritten by live values;
- a battery flag that can be written;
- a data output that stays driven during a write.

// File: rtl/rtc_nvram_pkg.sv
package rtc_nvram_pkg;

  localparam int NREG = 8;

  // Offsets of the clock bytes above the window base
  localparam int OFS_CENT = 0;
  localparam int OFS_SEC  = 1;
  localparam int OFS_MIN  = 2;
  localparam int OFS_HOUR = 3;
  localparam int OFS_DOW  = 4;
  localparam int OFS_DATE = 5;
  localparam int OFS_MON  = 6;
  localparam int OFS_YEAR = 7;

  typedef logic [NREG-1:0][7:0] regbank_t;

  // Bits carrying a time field, index 7 down to 0
  localparam regbank_t TIME_MASK =
    {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F, 8'h3F};

  // Year 00, Jan 01, day 1, 00:00:00, century 20
  localparam regbank_t TOD_RESET =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h20};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    logic [6:0] b;
    b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
  import rtc_nvram_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     stop_i,
  input  logic     load_i,
  input  regbank_t load_val_i,
  output regbank_t tod_o
);

  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);

  regbank_t        tod_q, tod_d;
  logic [PW-1:0]   pre_q, pre_d;
  logic            sec_adv;
  logic            tod_en;
  logic            pre_en;

  // Sub-second prescaler
  always_comb begin
    pre_d   = pre_q;
    sec_adv = 1'b0;
    if (load_i) begin
      pre_d = '0;
    end else if (tick_i && !stop_i) begin
      if (pre_q == PRE_LAST) begin
        pre_d   = '0;
        sec_adv = 1'b1;
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
  end

  // Calendar carry chain
  always_comb begin
    tod_d = tod_q;
    if (load_i) begin
      tod_d = load_val_i & TIME_MASK;
    end else if (sec_adv) begin
      if (tod_q[OFS_SEC] == 8'h59) begin
        tod_d[OFS_SEC] = 8'h00;
        if (tod_q[OFS_MIN] == 8'h59) begin
          tod_d[OFS_MIN] = 8'h00;
          if (tod_q[OFS_HOUR] == 8'h23) begin
            tod_d[OFS_HOUR] = 8'h00;
            tod_d[OFS_DOW]  = (tod_q[OFS_DOW] == 8'h07) ? 8'h01 : bcd_inc(tod_q[OFS_DOW]);
            if (tod_q[OFS_DATE] == month_end(tod_q[OFS_MON], tod_q[OFS_YEAR])) begin
              tod_d[OFS_DATE] = 8'h01;
              if (tod_q[OFS_MON] == 8'h12) begin
                tod_d[OFS_MON] = 8'h01;
                if (tod_q[OFS_YEAR] == 8'h99) begin
                  tod_d[OFS_YEAR] = 8'h00;
                  tod_d[OFS_CENT] = (tod_q[OFS_CENT] == 8'h39) ? 8'h00 : bcd_inc(tod_q[OFS_CENT]);
                end else begin
                  tod_d[OFS_YEAR] = bcd_inc(tod_q[OFS_YEAR]);
                end
              end else begin
                tod_d[OFS_MON] = bcd_inc(tod_q[OFS_MON]);
              end
            end else begin
              tod_d[OFS_DATE] = bcd_inc(tod_q[OFS_DATE]);
            end
          end else begin
            tod_d[OFS_HOUR] = bcd_inc(tod_q[OFS_HOUR]);
          end
        end else begin
          tod_d[OFS_MIN] = bcd_inc(tod_q[OFS_MIN]);
        end
      end else begin
        tod_d[OFS_SEC] = bcd_inc(tod_q[OFS_SEC]);
      end
    end
  end

  assign tod_en = load_i | sec_adv;
  assign pre_en = load_i | (tick_i & ~stop_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod_q <= TOD_RESET;
      pre_q <= '0;
    end else begin
      if (tod_en) tod_q <= tod_d;
      if (pre_en) pre_q <= pre_d;
    end
  end

  assign tod_o = tod_q;

  // R10: a stopped clock ignores the tick
  assert_stop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && stop_i && !load_i) |=> $stable(tod_q));

  // R8: releasing the write bit transfers the host values
  assert_load_transfers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (tod_q == ($past(load_val_i) & TIME_MASK)));

endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
  import rtc_nvram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [2:0] wr_ix_i,
  input  logic [7:0] wr_data_i,
  input  regbank_t   live_i,
  output regbank_t   user_o,
  output logic       load_o,
  output logic       stop_o,
  output logic       ftest_o
);

  regbank_t ureg_q, ureg_d;
  logic     load_q, load_d;
  logic     wbit, rbit, follow;

  assign wbit   = ureg_q[OFS_CENT][7];
  assign rbit   = ureg_q[OFS_CENT][6];
  assign follow = !wbit && !rbit && !load_q;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      ureg_d[i] = ureg_q[i];
      if (follow)
        ureg_d[i] = (ureg_q[i] & ~TIME_MASK[i]) | (live_i[i] & TIME_MASK[i]);
      if (wr_en_i && (wr_ix_i == 3'(i)))
        ureg_d[i] = (i == OFS_DOW) ? {1'b0, wr_data_i[6:0]} : wr_data_i;
    end
    load_d = wr_en_i && (wr_ix_i == 3'(OFS_CENT)) && wbit && !wr_data_i[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ureg_q <= TOD_RESET;
      load_q <= 1'b0;
    end else begin
      ureg_q <= ureg_d;
      load_q <= load_d;
    end
  end

  assign user_o  = ureg_q;
  assign load_o  = load_q;
  assign stop_o  = ureg_q[OFS_SEC][7];
  assign ftest_o = ureg_q[OFS_DOW][6];

  // R8: with the write bit set, only the host changes the holding bank
  assert_write_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wbit && !wr_en_i) |=> $stable(ureg_q));

  // R9: with the read bit set, the time fields are a stable snapshot
  assert_read_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rbit && !wr_en_i) |=> $stable(ureg_q & TIME_MASK));

endmodule

// File: rtl/rtc_nvram.sv
module rtc_nvram
  import rtc_nvram_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int TICKS_PER_SEC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              batt_low,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_en,
  output logic              ftest_out
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0] rst_pipe;
  logic       rst_ns;
  logic       bus_wr, bus_rd, in_clk;
  logic [2:0] clk_ix;
  logic [7:0] mem [DEPTH];
  logic [7:0] ubyte;
  regbank_t   user_bank, live_bank;
  logic       load, stop, ft_bit, ft_q;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  assign bus_wr = !ce_n && !we_n;
  assign bus_rd = !ce_n && !oe_n && we_n;
  assign in_clk = &addr[ADDR_W-1:3];
  assign clk_ix = addr[2:0];

  always_ff @(posedge clk) begin
    if (bus_wr && !in_clk) mem[addr] <= wdata;
  end

  rtc_user_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .wr_en_i   (bus_wr && in_clk),
    .wr_ix_i   (clk_ix),
    .wr_data_i (wdata),
    .live_i    (live_bank),
    .user_o    (user_bank),
    .load_o    (load),
    .stop_o    (stop),
    .ftest_o   (ft_bit)
  );

  rtc_tod_counter #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tod (
    .clk        (clk),
    .rst_n      (rst_ns),
    .tick_i     (sec_tick),
    .stop_i     (stop),
    .load_i     (load),
    .load_val_i (user_bank),
    .tod_o      (live_bank)
  );

  always_comb begin
    ubyte = user_bank[clk_ix];
    if (clk_ix == 3'(OFS_DOW)) ubyte[7] = !batt_low;
    rdata = 8'h00;
    if (bus_rd) rdata = in_clk ? ubyte : mem[addr];
  end
  assign rdata_en = bus_rd;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) ft_q <= 1'b0;
    else         ft_q <= ft_bit & sec_tick;
  end
  assign ftest_out = ft_q;

  // R11: the battery flag always mirrors the status input
  assert_batt_flag_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_rd && in_clk && clk_ix == 3'(OFS_DOW)) |-> (rdata[7] == !batt_low));

  // R12: the test output only ever follows a tick
  assert_ftest_source_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    ftest_out |-> $past(sec_tick));

endmodule

// File: tb/rtc_nvram_tb_top.sv
module rtc_nvram_tb_top;

  localparam int AW = 11;
  localparam logic [AW-1:0] BASE   = 11'h7F8;
  localparam logic [AW-1:0] A_CEN  = BASE + 11'd0;
  localparam logic [AW-1:0] A_SEC  = BASE + 11'd1;
  localparam logic [AW-1:0] A_MIN  = BASE + 11'd2;
  localparam logic [AW-1:0] A_HOUR = BASE + 11'd3;
  localparam logic [AW-1:0] A_DOW  = BASE + 11'd4;
  localparam logic [AW-1:0] A_DATE = BASE + 11'd5;
  localparam logic [AW-1:0] A_MON  = BASE + 11'd6;
  localparam logic [AW-1:0] A_YEAR = BASE + 11'd7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sec_tick = 1'b0;
  logic          batt_low = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          rdata_en, ftest_out;

  int vectors = 0;
  int miscompares = 0;
  logic sample_req = 1'b0;

  // Scoreboard queues: kind 0 = rdata, 1 = rdata_en, 2 = ftest_out
  int         kind_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] mask_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  rtc_nvram #(.ADDR_W(AW), .TICKS_PER_SEC(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .batt_low(batt_low),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_en(rdata_en), .ftest_out(ftest_out)
  );

  // Monitor
  int         m_kind;
  logic [7:0] m_exp, m_mask, m_act;
  string      m_tag;
  always @(negedge clk) begin
    if (sample_req) begin
      if (kind_q.size() == 0) begin
        miscompares++;
        $display("FAIL scoreboard: actual no item expected an item");
      end else begin
        m_kind = kind_q.pop_front();
        m_exp  = exp_q.pop_front();
        m_mask = mask_q.pop_front();
        m_tag  = tag_q.pop_front();
        m_act  = (m_kind == 0) ? rdata : (m_kind == 1) ? {7'b0, rdata_en} : {7'b0, ftest_out};
        vectors++;
        if ((m_act & m_mask) !== (m_exp & m_mask)) begin
          miscompares++;
          $display("FAIL %s: actual %02h expected %02h", m_tag, m_act & m_mask, m_exp & m_mask);
        end
      end
    end
  end

  task automatic push(input int k, input logic [7:0] e, input logic [7:0] m, input string t);
    kind_q.push_back(k); exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(posedge clk); #1;
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  // Write with output enable held active; the drive enable must be off
  task automatic wr_oe(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    push(1, 8'h00, 8'h01, "R2 drive off during write");
    sample_req = 1'b1;
    @(posedge clk); #1;
    sample_req = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input logic [7:0] m, input string t);
    @(posedge clk); #1;
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    push(0, e, m, t);
    sample_req = 1'b1;
    @(posedge clk); #1;
    sample_req = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic chk_en(input logic c, input logic o, input logic w, input logic e, input string t);
    @(posedge clk); #1;
    ce_n = c; oe_n = o; we_n = w; addr = '0;
    push(1, {7'b0, e}, 8'h01, t);
    sample_req = 1'b1;
    @(posedge clk); #1;
    sample_req = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 sec_tick = 1'b1;
      @(posedge clk); #1 sec_tick = 1'b0;
    end
    idle(2);
  endtask

  task automatic pulse_ft(input logic e, input string t);
    @(posedge clk); #1 sec_tick = 1'b1;
    @(posedge clk); #1 sec_tick = 1'b0;
    push(2, {7'b0, e}, 8'h01, t);
    sample_req = 1'b1;
    @(posedge clk); #1;
    push(2, 8'h00, 8'h01, t);
    @(posedge clk); #1;
    sample_req = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] c, input logic [7:0] y, input logic [7:0] mo,
                          input logic [7:0] dt, input logic [7:0] dw, input logic [7:0] h,
                          input logic [7:0] mi, input logic [7:0] s);
    wr(A_CEN, 8'h80 | c);
    wr(A_YEAR, y); wr(A_MON, mo); wr(A_DATE, dt); wr(A_DOW, dw);
    wr(A_HOUR, h); wr(A_MIN, mi); wr(A_SEC, s);
    wr(A_CEN, c);
    idle(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R13 reset state
    rd(A_CEN,  8'h20, 8'hFF, "R13 century");
    rd(A_YEAR, 8'h00, 8'hFF, "R13 year");
    rd(A_MON,  8'h01, 8'hFF, "R13 month");
    rd(A_DATE, 8'h01, 8'hFF, "R13 date");
    rd(A_DOW,  8'h81, 8'hFF, "R13 day");
    rd(A_HOUR, 8'h00, 8'hFF, "R13 hours");
    rd(A_MIN,  8'h00, 8'hFF, "R13 minutes");
    rd(A_SEC,  8'h00, 8'hFF, "R13 seconds");

    // R1 / R2 RAM behaviour and drive enable
    chk_en(1'b1, 1'b0, 1'b1, 1'b0, "R2 idle no drive");
    wr(11'h000, 8'hA5);
    wr(11'h7F7, 8'h3C);
    wr_oe(11'h555, 8'h5A);
    rd(11'h000, 8'hA5, 8'hFF, "R1 ram low");
    rd(11'h7F7, 8'h3C, 8'hFF, "R1 ram below window");
    rd(11'h555, 8'h5A, 8'hFF, "R2 write with oe low");
    chk_en(1'b0, 1'b0, 1'b1, 1'b1, "R1 read drives");

    // R5 R6: non-leap February
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    pulse(1);
    rd(A_SEC,  8'h00, 8'hFF, "R5 sec wrap");
    rd(A_MIN,  8'h00, 8'hFF, "R5 min wrap");
    rd(A_HOUR, 8'h00, 8'hFF, "R5 hour wrap");
    rd(A_DOW,  8'h04, 8'h07, "R5 day advance");
    rd(A_DATE, 8'h01, 8'hFF, "R6 feb 28 non-leap");
    rd(A_MON,  8'h03, 8'hFF, "R6 march");
    rd(A_YEAR, 8'h23, 8'hFF, "R3 year kept");

    // R6 leap February, R5 day 7 wrap
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
    pulse(1);
    rd(A_DATE, 8'h29, 8'hFF, "R6 feb 29 leap");
    rd(A_MON,  8'h02, 8'hFF, "R6 still feb");
    rd(A_DOW,  8'h01, 8'h07, "R5 day 7 wrap");
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse(1);
    rd(A_DATE, 8'h01, 8'hFF, "R6 feb 29 end");
    rd(A_MON,  8'h03, 8'hFF, "R6 leap march");
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(1);
    rd(A_DATE, 8'h29, 8'hFF, "R6 year 00 leap");
    set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(1);
    rd(A_DATE, 8'h01, 8'hFF, "R6 april 30 end");
    rd(A_MON,  8'h05, 8'hFF, "R6 may");

    // R7 year and century
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    pulse(1);
    rd(A_CEN,  8'h21, 8'hFF, "R7 century step");
    rd(A_YEAR, 8'h00, 8'hFF, "R7 year wrap");
    rd(A_MON,  8'h01, 8'hFF, "R7 month wrap");
    rd(A_DATE, 8'h01, 8'hFF, "R7 date wrap");
    set_time(8'h39, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    pulse(1);
    rd(A_CEN,  8'h00, 8'hFF, "R7 century 39 wrap");

    // R10 stop bit
    set_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h06, 8'h12, 8'h00, 8'h90);
    pulse(3);
    rd(A_SEC, 8'h90, 8'hFF, "R10 stopped");
    wr(A_SEC, 8'h10);
    idle(3);
    pulse(2);
    rd(A_SEC, 8'h12, 8'hFF, "R10 restarted");

    // R8 write bit
    wr(A_MIN, 8'h33);
    idle(3);
    rd(A_MIN, 8'h00, 8'hFF, "R8 write ignored without W");
    wr(A_CEN, 8'hA0);
    pulse(2);
    rd(A_SEC, 8'h12, 8'hFF, "R8 frozen during W");
    rd(A_CEN, 8'hA0, 8'hFF, "R8 control readback");
    wr(A_CEN, 8'h20);
    idle(3);
    rd(A_SEC, 8'h12, 8'hFF, "R8 reload drops ticks");
    pulse(1);
    rd(A_SEC, 8'h13, 8'hFF, "R8 counting after reload");

    // R9 read bit
    wr(A_CEN, 8'h60);
    pulse(2);
    rd(A_SEC, 8'h13, 8'hFF, "R9 snapshot held");
    rd(A_CEN, 8'h60, 8'hFF, "R9 control readback");
    wr(A_CEN, 8'h20);
    idle(3);
    rd(A_SEC, 8'h15, 8'hFF, "R9 live after clear");

    // R4 spare bits, R11 write to flag ignored
    wr(A_HOUR, 8'hC0);
    wr(A_MON,  8'hE0);
    wr(A_MIN,  8'h80);
    wr(A_DATE, 8'hC0);
    wr(A_DOW,  8'h38);
    idle(3);
    rd(A_HOUR, 8'hD2, 8'hFF, "R4 hour spares");
    rd(A_MON,  8'hE6, 8'hFF, "R4 month spares");
    rd(A_MIN,  8'h80, 8'hFF, "R4 minute spare");
    rd(A_DATE, 8'hD5, 8'hFF, "R4 date spares");
    rd(A_DOW,  8'hBE, 8'hFF, "R4 R11 day spares and flag");

    // R11 battery flag
    batt_low = 1'b1;
    wr(A_DOW, 8'hB8);
    idle(3);
    rd(A_DOW, 8'h00, 8'h80, "R11 flag low");
    batt_low = 1'b0;
    rd(A_DOW, 8'h80, 8'h80, "R11 flag high");

    // R12 frequency test
    pulse_ft(1'b0, "R12 disabled");
    wr(A_DOW, 8'h78);
    idle(3);
    pulse_ft(1'b1, "R12 enabled");

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule